// File: doc/BRIEF.md
# Microcontroller Strobe Bus to FIFO Bridge

This block lets an external microcontroller use an on-chip first-in first-out buffer over a plain asynchronous parallel bus. The buffer, its pointers and all control logic run on the FPGA's internal clock. The microcontroller drives two active-low strobes that have no fixed relation to that clock: one for reading and one for writing. Each strobe first passes through a two-flop synchronizer. Its edges are then decoded from the synchronized history. Every completed bus access therefore causes exactly one single-cycle push or pop, however many clock periods the strobe stays low.

When a write access begins, the write data is latched into a holding register. When the access ends, the latched word is pushed. During a read access the bus shows the oldest stored word and the output enable is driven. The pop happens when the read strobe returns high, so the next word is ready for the following access. A pop on an empty buffer, or a push on a full one, is discarded and sets a sticky error flag that only reset clears. The internal clock must run fast enough that every strobe pulse and every gap between pulses spans several clock periods.

Top module: `mcu_fifo_bridge`

## Requirements
- R1: After synchronous reset, with both strobes held high, the empty flag is 1, the full flag is 0, the error flag is 0 and the output enable is 0, and no operation takes place.
- R2: A write access pushes exactly one word, however long the write strobe stays low.
- R3: A read access pops exactly one word, however long the read strobe stays low.
- R4: The pushed word is the value on the data input when the synchronized write strobe falls. Later changes while the strobe is still low have no effect.
- R5: While the read strobe is low, the data output shows the oldest stored word, and words come out in the order they were written.
- R6: After DEPTH pushes the full flag is 1. A further write is discarded, leaving the contents unchanged, and it sets the error flag, which then stays set until reset.
- R7: A read while the buffer is empty is discarded and sets the error flag. The empty flag stays 1 and later writes and reads still work in order.
- R8: The output enable is 1 only while the synchronized read strobe is low. It is 0 when the bus is idle and during a write access.
- R9: The empty flag falls on the third rising clock edge after the write strobe returns high: two edges for the synchronizer and one for the registered push and flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal FPGA clock |
| rst | input | 1 | Synchronous reset, active high |
| mcu_rd_n | input | 1 | Read strobe, active low, asynchronous |
| mcu_wr_n | input | 1 | Write strobe, active low, asynchronous |
| mcu_data_in | input | DATA_W | Write data from the microcontroller |
| mcu_data_out | output | DATA_W | Oldest stored word, driven toward the bus |
| mcu_data_oe | output | 1 | Output enable for the bus driver |
| fifo_empty | output | 1 | Registered empty flag |
| fifo_full | output | 1 | Registered full flag |
| access_err | output | 1 | Sticky flag for a discarded push or pop |

## Verification
The hardest case to reach from the ports is a strobe held low for many clock periods. A broken edge decoder would then repeat the operation, and the fault stays hidden unless the buffer contents are counted afterwards. The bench holds strobes low for up to twelve cycles and then drains the buffer. A stray extra pop shows up as an early empty flag or an error, and a stray extra push shows up as a duplicate word. The data-capture point is checked by changing the write data partway through a held strobe. Full and empty overruns are reached by filling to DEPTH and by reading immediately after reset.

// File: rtl/mcu_bridge_pkg.sv
package mcu_bridge_pkg;

    // Decoded view of one synchronized active-low strobe
    typedef struct packed {
        logic active;   // synchronized level is low
        logic lead;     // high-to-low transition seen
        logic trail;    // low-to-high transition seen
    } strobe_evt_t;

    typedef enum logic {
        STROBE_RD = 1'b0,
        STROBE_WR = 1'b1
    } strobe_sel_e;

    localparam int unsigned NUM_STROBES = 2;

    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import mcu_bridge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_n,
    output strobe_evt_t evt
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    // chain[0..SYNC_STAGES-1] synchronizer, chain[SYNC_STAGES] history flop
    logic [CHAIN_W-1:0] chain;
    logic cur_lvl;
    logic prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;  // inactive level: no false edge at reset release
        end else begin
            chain <= {chain[CHAIN_W-2:0], strobe_n};
        end
    end

    assign cur_lvl  = chain[SYNC_STAGES-1];
    assign prev_lvl = chain[SYNC_STAGES];

    always_comb begin
        evt.active = ~cur_lvl;
        evt.lead   = prev_lvl & ~cur_lvl;
        evt.trail  = ~prev_lvl & cur_lvl;
    end

    // R2 R3: a trailing event never lasts two cycles
    assert_single_trail_R3: assert property (@(posedge clk) disable iff (rst)
        evt.trail |=> !evt.trail);

    // R4: a leading event is a one-cycle pulse too
    assert_single_lead_R4: assert property (@(posedge clk) disable iff (rst)
        evt.lead |=> !evt.lead);

endmodule

// File: rtl/fifo_core.sv
module fifo_core
    import mcu_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              push_drop,
    output logic              pop_drop
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic [CW-1:0]     count_next;
    logic              empty_q;
    logic              full_q;
    logic              push_ok;
    logic              pop_ok;

    initial begin
        if (!is_pow2(DEPTH)) $error("fifo_core: DEPTH must be a power of two");
    end

    assign push_ok   = push & ~full_q;
    assign pop_ok    = pop & ~empty_q;
    assign push_drop = push & full_q;
    assign pop_drop  = pop & empty_q;

    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   count_next = count + CW'(1);
            2'b01:   count_next = count - CW'(1);
            default: count_next = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            count   <= count_next;
            empty_q <= (count_next == '0);
            full_q  <= (count_next == CW'(DEPTH));
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = empty_q;
    assign full  = full_q;

    // R6: registered full flag agrees with occupancy
    assert_full_flag_R6: assert property (@(posedge clk) disable iff (rst)
        full_q |-> (count == CW'(DEPTH)));

    // R6: a refused push leaves the write pointer alone
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (push && full_q) |=> $stable(wr_ptr));

    // R7: a refused pop leaves the read pointer alone
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && empty_q) |=> $stable(rd_ptr));

    // R7: registered empty flag agrees with occupancy
    assert_empty_flag_R7: assert property (@(posedge clk) disable iff (rst)
        empty_q |-> (count == '0));

endmodule

// File: rtl/mcu_fifo_bridge.sv
module mcu_fifo_bridge
    import mcu_bridge_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEPTH       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mcu_rd_n,
    input  logic              mcu_wr_n,
    input  logic [DATA_W-1:0] mcu_data_in,
    output logic [DATA_W-1:0] mcu_data_out,
    output logic              mcu_data_oe,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              access_err
);
    logic [NUM_STROBES-1:0] strobe_n_vec;
    strobe_evt_t            evt [NUM_STROBES];
    strobe_evt_t            rd_evt;
    strobe_evt_t            wr_evt;
    logic [DATA_W-1:0]      wr_hold;
    logic                   push_drop;
    logic                   pop_drop;
    logic                   err_q;

    assign strobe_n_vec[STROBE_RD] = mcu_rd_n;
    assign strobe_n_vec[STROBE_WR] = mcu_wr_n;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
        strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
            .clk      (clk),
            .rst      (rst),
            .strobe_n (strobe_n_vec[g]),
            .evt      (evt[g])
        );
    end

    assign rd_evt = evt[STROBE_RD];
    assign wr_evt = evt[STROBE_WR];

    // Write data latched at the start of the access
    always_ff @(posedge clk) begin
        if (rst)              wr_hold <= '0;
        else if (wr_evt.lead) wr_hold <= mcu_data_in;
    end

    fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_evt.trail),
        .pop       (rd_evt.trail),
        .din       (wr_hold),
        .head      (mcu_data_out),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .push_drop (push_drop),
        .pop_drop  (pop_drop)
    );

    always_ff @(posedge clk) begin
        if (rst)                       err_q <= 1'b0;
        else if (push_drop | pop_drop) err_q <= 1'b1;
    end

    assign access_err  = err_q;
    assign mcu_data_oe = rd_evt.active;

    // R6 R7: error flag is sticky
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R8: bus is driven from the start of a read access
    assert_oe_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        rd_evt.lead |-> mcu_data_oe);

    // R8: bus released once the read access has ended
    assert_oe_off_R8: assert property (@(posedge clk) disable iff (rst)
        rd_evt.trail |-> !mcu_data_oe);

    // R4: a capture never coincides with the push of that access
    assert_capture_before_push_R4: assert property (@(posedge clk) disable iff (rst)
        wr_evt.lead |-> (wr_evt.active && !wr_evt.trail));

endmodule

// File: tb/mcu_fifo_bridge_tb_top.sv
module mcu_fifo_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 4;
    localparam int GAP        = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              mcu_rd_n;
    logic              mcu_wr_n;
    logic [DATA_W-1:0] mcu_data_in;
    logic [DATA_W-1:0] mcu_data_out;
    logic              mcu_data_oe;
    logic              fifo_empty;
    logic              fifo_full;
    logic              access_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_fifo_bridge #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .mcu_rd_n     (mcu_rd_n),
        .mcu_wr_n     (mcu_wr_n),
        .mcu_data_in  (mcu_data_in),
        .mcu_data_out (mcu_data_out),
        .mcu_data_oe  (mcu_data_oe),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .access_err   (access_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; mcu_rd_n = 1'b1; mcu_wr_n = 1'b1; mcu_data_in = '0;
        cycles(3);
        rst = 1'b0;
        cycles(2);
    endtask

    task automatic bus_write(input logic [DATA_W-1:0] d, input int low_cycles);
        @(negedge clk);
        mcu_data_in = d;
        mcu_wr_n    = 1'b0;
        cycles(low_cycles);
        mcu_wr_n = 1'b1;
        cycles(GAP);
    endtask

    task automatic bus_read(input int low_cycles, output logic [DATA_W-1:0] d,
                            output logic oe_seen);
        @(negedge clk);
        mcu_rd_n = 1'b0;
        cycles(3);
        d       = mcu_data_out;
        oe_seen = mcu_data_oe;
        if (low_cycles > 3) cycles(low_cycles - 3);
        mcu_rd_n = 1'b1;
        cycles(GAP);
    endtask

    task automatic t_reset_state();
        apply_reset();
        cycles(4);
        check("R1", "empty", fifo_empty, 1);
        check("R1", "full", fifo_full, 0);
        check("R1", "err", access_err, 0);
        check("R1", "oe", mcu_data_oe, 0);
    endtask

    task automatic t_empty_latency();
        logic [DATA_W-1:0] d;
        logic oe;
        apply_reset();
        @(negedge clk);
        mcu_data_in = 8'hA5; mcu_wr_n = 1'b0;
        cycles(4);
        mcu_wr_n = 1'b1;
        @(negedge clk);
        check("R9", "empty after 1 edge", fifo_empty, 1);
        @(negedge clk);
        check("R9", "empty after 2 edges", fifo_empty, 1);
        @(negedge clk);
        check("R9", "empty after 3 edges", fifo_empty, 0);
        cycles(GAP);
        bus_read(10, d, oe);
        check("R5", "head during read", d, 8'hA5);
        check("R3", "single pop empties", fifo_empty, 1);
        check("R3", "no extra pop error", access_err, 0);
    endtask

    task automatic t_long_write();
        logic [DATA_W-1:0] d;
        logic oe;
        apply_reset();
        bus_write(8'h11, 12);
        bus_write(8'h22, 3);
        bus_read(4, d, oe);
        check("R2", "first word", d, 8'h11);
        check("R2", "not empty after one read", fifo_empty, 0);
        bus_read(4, d, oe);
        check("R2", "second word not duplicate", d, 8'h22);
        check("R2", "drained", fifo_empty, 1);
        check("R2", "err", access_err, 0);
    endtask

    task automatic t_capture_point();
        logic [DATA_W-1:0] d;
        logic oe;
        apply_reset();
        @(negedge clk);
        mcu_data_in = 8'h3C; mcu_wr_n = 1'b0;
        cycles(4);
        mcu_data_in = 8'hC3;
        cycles(3);
        mcu_wr_n = 1'b1;
        cycles(GAP);
        bus_read(4, d, oe);
        check("R4", "captured at leading edge", d, 8'h3C);
    endtask

    task automatic t_fill_and_overflow();
        logic [DATA_W-1:0] d;
        logic oe;
        apply_reset();
        for (int i = 0; i < DEPTH; i++) bus_write(DATA_W'(8'h40 + i), 3 + i);
        check("R6", "full", fifo_full, 1);
        check("R6", "err before overflow", access_err, 0);
        bus_write(8'hEE, 3);
        check("R6", "err after overflow", access_err, 1);
        check("R6", "still full", fifo_full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(5, d, oe);
            check("R5", "order", d, DATA_W'(8'h40 + i));
        end
        check("R6", "dropped word absent", fifo_empty, 1);
        check("R6", "err sticky", access_err, 1);
    endtask

    task automatic t_underflow();
        logic [DATA_W-1:0] d;
        logic oe;
        apply_reset();
        bus_read(6, d, oe);
        check("R7", "err after empty read", access_err, 1);
        check("R7", "still empty", fifo_empty, 1);
        bus_write(8'h5A, 3);
        bus_write(8'h6B, 3);
        bus_read(4, d, oe);
        check("R7", "first after underflow", d, 8'h5A);
        bus_read(4, d, oe);
        check("R7", "second after underflow", d, 8'h6B);
    endtask

    task automatic t_output_enable();
        logic [DATA_W-1:0] d;
        logic oe;
        apply_reset();
        check("R8", "oe idle", mcu_data_oe, 0);
        @(negedge clk);
        mcu_data_in = 8'h77; mcu_wr_n = 1'b0;
        cycles(4);
        check("R8", "oe during write", mcu_data_oe, 0);
        mcu_wr_n = 1'b1;
        cycles(GAP);
        bus_read(6, d, oe);
        check("R8", "oe during read", oe, 1);
        check("R8", "oe after read", mcu_data_oe, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; mcu_rd_n = 1'b1; mcu_wr_n = 1'b1; mcu_data_in = '0;
        t_reset_state();
        t_empty_latency();
        t_long_write();
        t_capture_point();
        t_fill_and_overflow();
        t_underflow();
        t_output_enable();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule